// File: doc/BRIEF.md
# Rectangular Sprite Blitter

This block copies a rectangle of 8-bit pixels from a 128x128 page of graphics memory into a 128x128 half of a double-buffered framebuffer, moving one byte per clock once it is running. A one-cycle start pulse captures the source corner, the destination corner, the width and the height from the block's inputs. Two axis counters then walk the rectangle in row-major order: the horizontal counter steps every clock and reloads at the end of each row, and the vertical counter steps once per row. Both memories are synchronous: the block issues a read address, the pixel returns on the next clock, and the write to the framebuffer follows in that same cycle.

The most significant bit of the width (or height) reverses the direction in which the source is walked along that axis, so a stored sprite can be drawn mirrored. The most significant bit of the destination X (or Y) selects clipping on that axis: pixels that fall past the 128-pixel edge are dropped instead of wrapping round to the opposite side. With transparency enabled, zero-valued source bytes are not written. Completion can raise an interrupt that stays high until it is acknowledged. Register decode and bus arbitration sit outside the block.

Top module: `blit_engine`

## Requirements
- R1: After an accepted start with width magnitude W and height magnitude H (both nonzero), busy is high for exactly W*H+1 consecutive cycles, and framebuffer pixel (dx+i, dy+j) receives graphics pixel (sx+i, sy+j) for 0<=i<W, 0<=j<H, coordinates taken modulo 128.
- R2: The read address is {page, Y[6:0], X[6:0]} and the write address is {half, Y[6:0], X[6:0]}; page select, framebuffer half select and the transparency setting are captured at the start pulse.
- R3: A copy performs exactly one write per pixel of the rectangle that is not clipped or skipped, and no other write: no extra pixel follows the last one.
- R4: With transparency enabled, a source byte equal to zero is not written; with it disabled, zero bytes are written like any other.
- R5: With width bit 7 set, the source X walks downward from sx (modulo 128) while the destination X still walks upward.
- R6: With height bit 7 set, the source Y walks downward from sy (modulo 128) while the destination Y still walks upward.
- R7: With destination X bit 7 set, a pixel whose destination column dx[6:0]+i is 128 or more is not written.
- R8: With destination Y bit 7 set, a pixel whose destination row dy[6:0]+j is 128 or more is not written.
- R9: With the destination clip bit clear, a column or row past 127 wraps to the opposite edge of the framebuffer.
- R10: A start with width or height magnitude (bits 6:0) equal to zero makes no write, never raises busy, and completes at once.
- R11: A start pulse while busy is high is ignored: the running copy and its length are unchanged.
- R12: At completion the interrupt rises only if the completion-interrupt enable is high, and once high it stays high until an acknowledge.
- R13: After reset busy, the write enable and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| src_x | input | 7 | Source corner column |
| src_y | input | 7 | Source corner row |
| dst_x | input | 8 | Destination corner column; bit 7 enables clipping in X |
| dst_y | input | 8 | Destination corner row; bit 7 enables clipping in Y |
| size_w | input | 8 | Width magnitude in bits 6:0; bit 7 mirrors the source in X |
| size_h | input | 8 | Height magnitude in bits 6:0; bit 7 mirrors the source in Y |
| transp_en | input | 1 | Skip zero-valued source pixels |
| irq_en | input | 1 | Raise the interrupt at completion |
| irq_ack | input | 1 | Clear a pending interrupt |
| gfx_page | input | 1 | Graphics memory page for the copy |
| fb_half | input | 1 | Framebuffer half written by the copy |
| gfx_raddr | output | 15 | Graphics memory read address |
| gfx_rdata | input | 8 | Graphics memory read data, one cycle after the address |
| fb_waddr | output | 15 | Framebuffer write address |
| fb_wdata | output | 8 | Framebuffer write data |
| fb_we | output | 1 | Framebuffer write enable |
| busy | output | 1 | Copy in progress |
| irq | output | 1 | Completion interrupt, held until acknowledged |

## Verification
The bench compares the whole set of written framebuffer locations after each copy with a model, so a design that emitted one write too many after the last pixel, as a counter stepping once more at completion would, shows up as a stray address and a wrong write count. Mirrored copies catch a design that walked the destination backwards or forgot to wrap the source below zero, and copies placed near the right and bottom edges with and without the clip bit catch wrapping where clipping was asked for and the reverse. Zero-size starts, starts issued mid-copy and an interrupt left unacknowledged for several cycles target a design that would hang busy, restart the rectangle, or drop its interrupt early.

// File: rtl/blit_pkg.sv
// Shared definitions for the sprite blitter.
// Assumes: coordinates are unsigned and wrap modulo 2**width.
package blit_pkg;

    // Direction in which a source coordinate is walked
    typedef enum logic {
        WALK_UP   = 1'b0,
        WALK_DOWN = 1'b1
    } walk_dir_e;

    // Next source coordinate for one step in the given direction
    function automatic logic [15:0] walk_next(input logic [15:0] pos, input walk_dir_e dir);
        return (dir == WALK_DOWN) ? pos - 16'd1 : pos + 16'd1;
    endfunction

endpackage

// File: rtl/blit_axis.sv
// One axis of the blitter: a source coordinate that walks up or down,
// a destination coordinate that walks up with one extra carry bit for
// edge detection, and a count of steps left in the span.
// Assumes: start is never asserted with a zero magnitude, and advance is
// never asserted together with last (the owner reloads instead).
module blit_axis
    import blit_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          restart,
    input  logic          advance,
    input  logic [CW-1:0] org_src,
    input  logic [CW:0]   org_dst,
    input  logic [CW:0]   span,
    output logic [CW-1:0] src_pos,
    output logic [CW-1:0] dst_pos,
    output logic          outside,
    output logic          last
);

    logic [CW-1:0] src_org_q;
    logic [CW-1:0] dst_org_q;
    logic [CW-1:0] mag_q;
    walk_dir_e     dir_q;
    logic          clip_q;

    logic [CW-1:0] src_q;
    logic [CW:0]   dst_q;
    logic [CW-1:0] left_q;
    logic [15:0]   src_step;

    // Keep the origin and options of the span for reloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_org_q <= '0;
            dst_org_q <= '0;
            mag_q     <= '0;
            dir_q     <= WALK_UP;
            clip_q    <= 1'b0;
        end else if (start) begin
            src_org_q <= org_src;
            dst_org_q <= org_dst[CW-1:0];
            mag_q     <= span[CW-1:0];
            dir_q     <= walk_dir_e'(span[CW]);
            clip_q    <= org_dst[CW];
        end
    end

    assign src_step = walk_next(16'(src_q), dir_q);

    // Load, reload or step the position and remaining-count counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
        end else if (start) begin
            src_q  <= org_src;
            dst_q  <= {1'b0, org_dst[CW-1:0]};
            left_q <= span[CW-1:0];
        end else if (restart) begin
            src_q  <= src_org_q;
            dst_q  <= {1'b0, dst_org_q};
            left_q <= mag_q;
        end else if (advance) begin
            src_q  <= src_step[CW-1:0];
            dst_q  <= dst_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign src_pos = src_q;
    assign dst_pos = dst_q[CW-1:0];
    assign outside = clip_q & dst_q[CW];
    assign last    = (left_q == CW'(1));

    // R1
    adv_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last);

    // R1
    adv_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start && !restart) |=> left_q != '0);

endmodule

// File: rtl/blit_irq.sv
// Completion interrupt latch: set by the engine, cleared by an acknowledge.
// Assumes: a set and an acknowledge in the same cycle leave it set.
module blit_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);

    logic irq_q;

    // Hold the request until it is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (set) irq_q <= 1'b1;
        else if (ack) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R12
    irq_no_self_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !set) |=> !irq);

endmodule

// File: rtl/blit_engine.sv
// Rectangular sprite blitter top. Walks a rectangle in row-major order,
// issuing one graphics read per clock and writing the returned pixel to
// the framebuffer one cycle later.
// Assumes: graphics memory returns read data one clock after the address;
// the framebuffer accepts one write per clock.
module blit_engine #(
    parameter int CW = 7,
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     src_x,
    input  logic [CW-1:0]     src_y,
    input  logic [CW:0]       dst_x,
    input  logic [CW:0]       dst_y,
    input  logic [CW:0]       size_w,
    input  logic [CW:0]       size_h,
    input  logic              transp_en,
    input  logic              irq_en,
    input  logic              irq_ack,
    input  logic              gfx_page,
    input  logic              fb_half,
    output logic [2*CW:0]     gfx_raddr,
    input  logic [PW-1:0]     gfx_rdata,
    output logic [2*CW:0]     fb_waddr,
    output logic [PW-1:0]     fb_wdata,
    output logic              fb_we,
    output logic              busy,
    output logic              irq
);

    localparam int AW = 2 * CW + 1;

    logic          run_q;
    logic          page_q, half_q, transp_q;
    logic          empty, go, go_empty;
    logic          row_end, finish;
    logic          x_last, y_last, x_out, y_out;
    logic [CW-1:0] x_src, y_src, x_dst, y_dst;

    logic          wr_valid_q, wr_last_q, wr_clip_q;
    logic [AW-1:0] wr_addr_q;

    assign empty    = (size_w[CW-1:0] == '0) || (size_h[CW-1:0] == '0);
    assign go       = start && !busy && !empty;
    assign go_empty = start && !busy && empty;
    assign row_end  = run_q && x_last;
    assign finish   = row_end && y_last;

    // Horizontal axis: steps every pixel, reloads at each row end
    blit_axis #(.CW(CW)) u_axis_x (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go),
        .restart (row_end),
        .advance (run_q && !x_last),
        .org_src (src_x),
        .org_dst (dst_x),
        .span    (size_w),
        .src_pos (x_src),
        .dst_pos (x_dst),
        .outside (x_out),
        .last    (x_last)
    );

    // Vertical axis: steps once per completed row
    blit_axis #(.CW(CW)) u_axis_y (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go),
        .restart (1'b0),
        .advance (row_end && !y_last),
        .org_src (src_y),
        .org_dst (dst_y),
        .span    (size_h),
        .src_pos (y_src),
        .dst_pos (y_dst),
        .outside (y_out),
        .last    (y_last)
    );

    // Running flag: set by an accepted start, cleared after the last read
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (go)     run_q <= 1'b1;
        else if (finish) run_q <= 1'b0;
    end

    // Capture the per-copy memory selects and transparency at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= 1'b0;
            half_q   <= 1'b0;
            transp_q <= 1'b0;
        end else if (go) begin
            page_q   <= gfx_page;
            half_q   <= fb_half;
            transp_q <= transp_en;
        end
    end

    assign gfx_raddr = {page_q, y_src, x_src};

    // Write stage: line up the destination with the returning read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_last_q  <= 1'b0;
            wr_clip_q  <= 1'b0;
            wr_addr_q  <= '0;
        end else begin
            wr_valid_q <= run_q;
            wr_last_q  <= finish;
            wr_clip_q  <= x_out || y_out;
            wr_addr_q  <= {half_q, y_dst, x_dst};
        end
    end

    assign fb_waddr = wr_addr_q;
    assign fb_wdata = gfx_rdata;
    assign fb_we    = wr_valid_q && !wr_clip_q && !(transp_q && (gfx_rdata == '0));
    assign busy     = run_q || wr_valid_q;

    // Completion interrupt
    blit_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_en && ((wr_valid_q && wr_last_q) || go_empty)),
        .ack   (irq_ack),
        .irq   (irq)
    );

    // R3
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> wr_valid_q);

    // R1
    run_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !run_q);

    // R3
    no_write_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_q && wr_last_q) |=> !fb_we);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && start && !finish) |=> run_q);

    // R10
    empty_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_empty |=> !busy);

endmodule

// File: tb/blit_engine_test.sv
// Bench for the sprite blitter: synchronous graphics memory computed from
// the address, framebuffer captured in an associative array.
module blit_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  src_x = '0, src_y = '0;
    logic [7:0]  dst_x = '0, dst_y = '0, size_w = '0, size_h = '0;
    logic        transp_en = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic        gfx_page = 1'b0, fb_half = 1'b0;
    logic [14:0] gfx_raddr, fb_waddr;
    logic [7:0]  gfx_rdata = '0, fb_wdata;
    logic        fb_we, busy, irq;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    bit finished = 1'b0;
    logic [7:0] fb_mem [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    blit_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .size_w(size_w), .size_h(size_h), .transp_en(transp_en),
        .irq_en(irq_en), .irq_ack(irq_ack), .gfx_page(gfx_page),
        .fb_half(fb_half), .gfx_raddr(gfx_raddr), .gfx_rdata(gfx_rdata),
        .fb_waddr(fb_waddr), .fb_wdata(fb_wdata), .fb_we(fb_we),
        .busy(busy), .irq(irq)
    );

    function automatic logic [7:0] gpix(input int a);
        logic [7:0] v;
        v = 8'(a * 29 + (a >>> 7) * 3 + 5);
        if (a % 5 == 0) v = 8'd0;
        return v;
    endfunction

    // Graphics memory model: one-cycle read latency
    always @(posedge clk) gfx_rdata <= gpix(int'(gfx_raddr));

    // Framebuffer model
    always @(posedge clk) begin
        if (fb_we) begin
            fb_mem[int'(fb_waddr)] = fb_wdata;
            wcount++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_job(input logic [6:0] sx, input logic [6:0] sy,
                           input logic [7:0] dx, input logic [7:0] dy,
                           input logic [7:0] w, input logic [7:0] h,
                           input bit tr, input bit ie, input bit pg, input bit fs,
                           input bit poke, input string tag);
        logic [7:0] exp_mem [int];
        int cycles, bad, first_key, wm, hm;
        wm = int'(w[6:0]);
        hm = int'(h[6:0]);
        for (int j = 0; j < hm; j++) begin
            for (int i = 0; i < wm; i++) begin
                int sxi, syi, dxi, dyi, key;
                logic [7:0] p;
                sxi = (h[7] ? 0 : 0) + (w[7] ? (int'(sx) - i) : (int'(sx) + i));
                syi = h[7] ? (int'(sy) - j) : (int'(sy) + j);
                sxi = sxi & 127;
                syi = syi & 127;
                dxi = int'(dx[6:0]) + i;
                dyi = int'(dy[6:0]) + j;
                if (dx[7] && dxi >= 128) continue;
                if (dy[7] && dyi >= 128) continue;
                p = gpix(int'(pg) * 16384 + syi * 128 + sxi);
                if (tr && p == 8'd0) continue;
                key = int'(fs) * 16384 + (dyi & 127) * 128 + (dxi & 127);
                exp_mem[key] = p;
            end
        end
        fb_mem.delete();
        wcount = 0;
        @(negedge clk);
        src_x = sx; src_y = sy; dst_x = dx; dst_y = dy; size_w = w; size_h = h;
        transp_en = tr; irq_en = ie; gfx_page = pg; fb_half = fs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (busy && cycles < 40000) begin
            cycles++;
            if (poke && cycles == 3) begin
                // R11: a second request mid-copy with different settings
                src_x = sx + 7'd9; dst_x = dx ^ 8'h15; size_w = 8'd3; size_h = 8'd2;
                fb_half = ~fs; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(cycles == wm * hm + 1, "R1", {tag, " busy length"}, cycles, wm * hm + 1);
        bad = 0;
        first_key = -1;
        foreach (exp_mem[k]) begin
            if (!fb_mem.exists(k) || fb_mem[k] != exp_mem[k]) begin
                bad++;
                if (first_key < 0) first_key = k;
            end
        end
        if (fb_mem.num() != exp_mem.num()) bad++;
        check(bad == 0, tag, "framebuffer contents (mismatches, first bad address)", bad, first_key);
        check(wcount == exp_mem.num(), "R3", {tag, " write count"}, wcount, exp_mem.num());
        check(irq == ie, "R12", {tag, " interrupt at completion"}, int'(irq), int'(ie));
        repeat (3) @(negedge clk);
        check(irq == ie, "R12", {tag, " interrupt held"}, int'(irq), int'(ie));
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq == 1'b0, "R12", {tag, " interrupt cleared"}, int'(irq), 0);
    endtask

    task automatic run_empty(input logic [7:0] w, input logic [7:0] h, input bit ie);
        int seen_busy;
        wcount = 0;
        @(negedge clk);
        size_w = w; size_h = h; irq_en = ie; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(irq == ie, "R10", "empty copy interrupt", int'(irq), int'(ie));
        seen_busy = 0;
        repeat (4) begin
            if (busy) seen_busy++;
            @(negedge clk);
        end
        check(seen_busy == 0, "R10", "empty copy busy cycles", seen_busy, 0);
        check(wcount == 0, "R10", "empty copy writes", wcount, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R13: reset state
        check(busy == 1'b0, "R13", "busy in reset", int'(busy), 0);
        check(fb_we == 1'b0, "R13", "write enable in reset", int'(fb_we), 0);
        check(irq == 1'b0, "R13", "interrupt in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R13", "busy after reset", int'(busy), 0);

        run_job(7'd10, 7'd20, 8'd30, 8'd40, 8'd4, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        run_job(7'd100, 7'd5, 8'd3, 8'd90, 8'd6, 8'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        run_job(7'd2, 7'd50, 8'd60, 8'd10, 8'h88, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        run_job(7'd40, 7'd1, 8'd20, 8'd20, 8'd5, 8'h86, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        run_job(7'd0, 7'd0, 8'd0, 8'd0, 8'd20, 8'd10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run_job(7'd0, 7'd0, 8'd0, 8'd0, 8'd20, 8'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        run_job(7'd5, 7'd5, 8'h80 | 8'd120, 8'd30, 8'd16, 8'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        run_job(7'd5, 7'd5, 8'd120, 8'd30, 8'd16, 8'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        run_job(7'd5, 7'd5, 8'd10, 8'h80 | 8'd125, 8'd4, 8'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        run_job(7'd5, 7'd5, 8'd10, 8'd125, 8'd4, 8'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        run_job(7'd64, 7'd64, 8'd8, 8'd8, 8'd12, 8'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
        run_job(7'd1, 7'd2, 8'd3, 8'd4, 8'd5, 8'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        run_job(7'd127, 7'd0, 8'h80 | 8'd100, 8'h80 | 8'd100, 8'h80 | 8'd40, 8'h80 | 8'd40,
                1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        run_job(7'd0, 7'd0, 8'd0, 8'd0, 8'd127, 8'd127, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        run_empty(8'd0, 8'd5, 1'b1);
        run_empty(8'h80, 8'd7, 1'b1);
        run_empty(8'd3, 8'd0, 1'b0);

        for (int n = 0; n < 24; n++) begin
            logic [7:0] rw, rh, rdx, rdy;
            rw  = 8'(1 + ($urandom() % 20)) | (($urandom() % 2) != 0 ? 8'h80 : 8'h00);
            rh  = 8'(1 + ($urandom() % 20)) | (($urandom() % 2) != 0 ? 8'h80 : 8'h00);
            rdx = 8'($urandom());
            rdy = 8'($urandom());
            run_job(7'($urandom()), 7'($urandom()), rdx, rdy, rw, rh,
                    1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                    1'(($urandom() % 4) == 0), "R1");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule